// File: doc/BRIEF.md
# SD Card Command Engine

This block runs the command line of an SD card for one command at a time. Software loads a 32-bit argument and a response timeout through a small write port. It then writes a command word that holds the command index, the response options and a start flag. The engine builds a 48-bit command frame with its CRC7 and shifts it onto the command line, one bit per card-clock strobe. Depending on the command word it then finishes, or it waits for a 48-bit or a 136-bit response. After a short response it can also wait for the card to release DAT0.

The start flag stays set while the command is in progress and drops when the command ends. A command that ends badly also raises a fail flag in the command word. The cause goes into a status register whose bits are cleared by writing 1 to them. The received response is held in four 32-bit words. The card clock is generated elsewhere and reaches the engine as a single-cycle enable strobe.

Top module: `sd_cmd_engine`

## Requirements
- R1: After reset the command word, the status register and all four response words read 0, `cmd_oe` is low and `cmd_out` is high.
- R2: The write port decodes `reg_addr` as 0 = command word, 1 = argument, 2 = timeout start value, 3 = status clear. The command word has the index in bits 5:0, read in bit 6, write in bit 7, long response in bit 9, no response in bit 10, busy wait in bit 11, fail in bit 14 and start/in-progress in bit 15; bit 8 and bits 13:12 read 0. A write to address 0 with bit 15 set, made while bit 15 reads 0, starts a command, and bit 15 reads 1 from the next cycle until the command ends.
- R3: A command frame is 48 bits, most significant first: 0, 1, the index, the argument, CRC7 (x^7+x^3+1, zero seed) over those first 40 bits, then 1. `cmd_oe` is high during the frame. The first bit is driven from the cycle after the start, and each strobe moves to the next bit. The line is released after the 48th strobe.
- R4: A write to the command word while bit 15 reads 1 is ignored entirely.
- R5: With the no-response bit set, the command ends on the 48th strobe of the frame, with no status bit and no fail flag.
- R6: With timeout start value T, if the command line is high on T+1 consecutive strobes while the engine waits for a start bit, status bit 6 (0x040) and the fail flag are set and the command ends.
- R7: A short response is 48 bits, counted from the start bit 0. Bits 39:8 go into response word 0, and the other three words keep their values. If the CRC7 over bits 47:8 does not match bits 7:1, status bit 4 (0x010) and the fail flag are set and the command ends.
- R8: A long response is 136 bits. Its bits 127:0 fill response words 0 to 3, with word 3 taking bits 127:96. No CRC check is made.
- R9: With busy wait set and a good short response, the engine samples DAT0 on each strobe. When DAT0 is high it sets status bit 10 (0x400) and ends the command. If DAT0 stays low on T+1 strobes, it sets status bit 7 (0x080) and the fail flag instead.
- R10: Writing to address 3 clears every status bit whose write-data bit is 1.
- R11: A start request with both long response and busy wait set does not start. Bit 15 stays 0, the fail flag is set, the fields are stored and no frame is driven.
- R12: Starting a command clears the fail flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Card-clock strobe, one cycle wide |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for writes |
| reg_wdata | input | 32 | Write data |
| cmd_in | input | 1 | Command line as seen from the card |
| dat0_in | input | 1 | DAT0 line, low while the card is busy |
| cmd_out | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Command line drive enable |
| cmd_word | output | 16 | Command word readback |
| status | output | 11 | Status flags |
| rsp_w0 | output | 32 | Response bits 31:0 |
| rsp_w1 | output | 32 | Response bits 63:32 |
| rsp_w2 | output | 32 | Response bits 95:64 |
| rsp_w3 | output | 32 | Response bits 127:96 |

## Verification
A bit counter in the transmitter that is off by one shows on `cmd_out` at the next strobe, or as `cmd_oe` dropping one strobe early or late. A wrong receive count or a wrong shift direction shows up when the response completes. The response words then hold shifted data, or a false CRC7 flag appears. A timeout counter that loads or expires wrongly moves the rise of the timeout flag and the fall of the start flag by at least one strobe. All of these are compared against an independent model on every clock, so any deviation is reported within one cycle of its appearance at the ports.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int FRAME_LEN = 48;
  localparam int LONG_LEN  = 136;
  localparam int CNT_W     = $clog2(LONG_LEN + 1);
  localparam int STS_W     = 11;
  localparam int CRC_W     = 7;
  localparam int HEAD_LEN  = FRAME_LEN - CRC_W - 1;

  // command word fields
  localparam int B_LONG  = 9;
  localparam int B_NORSP = 10;
  localparam int B_BUSY  = 11;
  localparam int B_FAIL  = 14;
  localparam int B_NEW   = 15;
  localparam logic [11:0] FIELD_MASK = 12'hEFF;

  // status causes
  localparam int S_CRC7      = 4;
  localparam int S_CMD_TO    = 6;
  localparam int S_REW_TO    = 7;
  localparam int S_BUSY_DONE = 10;

  localparam logic [1:0] A_CMD = 2'd0;
  localparam logic [1:0] A_ARG = 2'd1;
  localparam logic [1:0] A_TMO = 2'd2;
  localparam logic [1:0] A_STS = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEND, ST_WAIT, ST_RECV, ST_BUSY
  } eng_state_e;

  // serial CRC7, polynomial x^7 + x^3 + 1, zero seed
  function automatic logic [CRC_W-1:0] crc7_f(input logic [HEAD_LEN-1:0] d);
    logic [CRC_W-1:0] c;
    logic             fb;
    c = '0;
    for (int i = HEAD_LEN - 1; i >= 0; i--) begin
      fb = d[i] ^ c[CRC_W-1];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction
endpackage

// File: rtl/sdc_tx.sv
module sdc_tx
  import sdc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [FRAME_LEN-1:0] frame,
  input  logic                 shift,
  output logic                 bit_o,
  output logic                 last_o
);
  logic [FRAME_LEN-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (load) begin
      sh_d  = frame;
      cnt_d = '0;
    end else if (shift) begin
      sh_d  = {sh_q[FRAME_LEN-2:0], 1'b1};
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '1;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign bit_o  = sh_q[FRAME_LEN-1];
  assign last_o = (cnt_q == CNT_W'(FRAME_LEN - 1));

  AST_TX_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> (cnt_q < CNT_W'(FRAME_LEN))); // R3
endmodule

// File: rtl/sdc_rx.sv
module sdc_rx #(
  parameter int LEN = 136,
  parameter int CW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           shift,
  input  logic           bit_i,
  output logic [LEN-1:0] word_o,
  output logic [CW-1:0]  cnt_o
);
  logic [LEN-1:0] sh_q, sh_d;
  logic [CW-1:0]  cnt_q, cnt_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (start) begin
      sh_d  = '0;
      cnt_d = CW'(1);
    end else if (shift) begin
      sh_d  = {sh_q[LEN-2:0], bit_i};
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  // word as it stands once the bit on the line is taken in
  assign word_o = {sh_q[LEN-2:0], bit_i};
  assign cnt_o  = cnt_q;

  AST_RX_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> (cnt_q < CW'(LEN))); // R8
endmodule

// File: rtl/sdc_tmo.sv
module sdc_tmo #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] init,
  input  logic         dec,
  output logic         zero_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                   cnt_d = init;
    else if (dec && cnt_q != 0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  AST_TMO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (cnt_q != '0)); // R6
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
  import sdc_pkg::*;
#(
  parameter int TMO_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clk_en,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic        cmd_in,
  input  logic        dat0_in,
  output logic        cmd_out,
  output logic        cmd_oe,
  output logic [15:0] cmd_word,
  output logic [10:0] status,
  output logic [31:0] rsp_w0,
  output logic [31:0] rsp_w1,
  output logic [31:0] rsp_w2,
  output logic [31:0] rsp_w3
);
  localparam logic [CNT_W-1:0] NEED_SHORT = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] NEED_LONG  = CNT_W'(LONG_LEN - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s = rsync_q[1];

  eng_state_e        state_q, state_d;
  logic              new_q, new_d, fail_q, fail_d;
  logic [11:0]       cf_q, cf_d;
  logic [31:0]       arg_q, arg_d;
  logic [TMO_W-1:0]  tmo_q, tmo_d;
  logic [STS_W-1:0]  sts_q, sts_d, sts_set, sts_clr;
  logic [3:0][31:0]  rsp_q, rsp_d;

  logic              fin, tx_load, tmo_load, tmo_dec, rx_start, rx_shift;
  logic              tx_bit, tx_last, tmo_zero;
  logic [LONG_LEN-1:0] rx_word;
  logic [CNT_W-1:0]  rx_cnt, rx_need;
  logic [FRAME_LEN-1:0] tx_frame;
  logic              wr_cmd;

  assign wr_cmd   = reg_wr && (reg_addr == A_CMD);
  assign rx_need  = cf_q[B_LONG] ? NEED_LONG : NEED_SHORT;
  assign tx_frame = {2'b01, reg_wdata[5:0], arg_q,
                     crc7_f({2'b01, reg_wdata[5:0], arg_q}), 1'b1};

  sdc_tx i_tx (
    .clk(clk), .rst_n(rst_s), .load(tx_load), .frame(tx_frame),
    .shift(clk_en && state_q == ST_SEND), .bit_o(tx_bit), .last_o(tx_last)
  );

  sdc_rx #(.LEN(LONG_LEN), .CW(CNT_W)) i_rx (
    .clk(clk), .rst_n(rst_s), .start(rx_start), .shift(rx_shift),
    .bit_i(cmd_in), .word_o(rx_word), .cnt_o(rx_cnt)
  );

  sdc_tmo #(.W(TMO_W)) i_tmo (
    .clk(clk), .rst_n(rst_s), .load(tmo_load), .init(tmo_q),
    .dec(tmo_dec), .zero_o(tmo_zero)
  );

  always_comb begin
    state_d  = state_q;
    new_d    = new_q;
    fail_d   = fail_q;
    cf_d     = cf_q;
    arg_d    = arg_q;
    tmo_d    = tmo_q;
    rsp_d    = rsp_q;
    sts_set  = '0;
    fin      = 1'b0;
    tx_load  = 1'b0;
    tmo_load = 1'b0;
    tmo_dec  = 1'b0;
    rx_start = 1'b0;
    rx_shift = 1'b0;

    case (state_q)
      ST_SEND: if (clk_en && tx_last) begin
        if (cf_q[B_NORSP]) fin = 1'b1;
        else begin
          state_d  = ST_WAIT;
          tmo_load = 1'b1;
        end
      end
      ST_WAIT: if (clk_en) begin
        if (!cmd_in) begin
          rx_start = 1'b1;
          state_d  = ST_RECV;
        end else if (tmo_zero) begin
          sts_set[S_CMD_TO] = 1'b1;
          fail_d = 1'b1;
          fin    = 1'b1;
        end else tmo_dec = 1'b1;
      end
      ST_RECV: if (clk_en) begin
        if (rx_cnt == rx_need) begin
          if (cf_q[B_LONG]) begin
            rsp_d = rx_word[127:0];
            fin   = 1'b1;
          end else begin
            rsp_d[0] = rx_word[39:8];
            if (crc7_f(rx_word[47:8]) != rx_word[7:1]) begin
              sts_set[S_CRC7] = 1'b1;
              fail_d = 1'b1;
              fin    = 1'b1;
            end else if (cf_q[B_BUSY]) begin
              state_d  = ST_BUSY;
              tmo_load = 1'b1;
            end else fin = 1'b1;
          end
        end else rx_shift = 1'b1;
      end
      ST_BUSY: if (clk_en) begin
        if (dat0_in) begin
          sts_set[S_BUSY_DONE] = 1'b1;
          fin = 1'b1;
        end else if (tmo_zero) begin
          sts_set[S_REW_TO] = 1'b1;
          fail_d = 1'b1;
          fin    = 1'b1;
        end else tmo_dec = 1'b1;
      end
      default: ;
    endcase

    if (fin) begin
      state_d = ST_IDLE;
      new_d   = 1'b0;
    end

    if (wr_cmd && !new_q) begin
      cf_d = reg_wdata[11:0] & FIELD_MASK;
      if (reg_wdata[B_NEW]) begin
        if (reg_wdata[B_LONG] && reg_wdata[B_BUSY]) begin
          fail_d = 1'b1;
        end else begin
          new_d   = 1'b1;
          fail_d  = 1'b0;
          state_d = ST_SEND;
          tx_load = 1'b1;
        end
      end
    end

    if (reg_wr && reg_addr == A_ARG) arg_d = reg_wdata;
    if (reg_wr && reg_addr == A_TMO) tmo_d = reg_wdata[TMO_W-1:0];
    sts_clr = (reg_wr && reg_addr == A_STS) ? reg_wdata[STS_W-1:0] : '0;
    sts_d   = (sts_q & ~sts_clr) | sts_set;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= ST_IDLE;
      new_q   <= 1'b0;
      fail_q  <= 1'b0;
      cf_q    <= '0;
      arg_q   <= '0;
      tmo_q   <= '0;
      sts_q   <= '0;
      rsp_q   <= '0;
    end else begin
      state_q <= state_d;
      new_q   <= new_d;
      fail_q  <= fail_d;
      cf_q    <= cf_d;
      arg_q   <= arg_d;
      tmo_q   <= tmo_d;
      sts_q   <= sts_d;
      rsp_q   <= rsp_d;
    end
  end

  assign cmd_oe   = (state_q == ST_SEND);
  assign cmd_out  = cmd_oe ? tx_bit : 1'b1;
  assign cmd_word = {new_q, fail_q, 2'b00, cf_q};
  assign status   = sts_q;
  assign rsp_w0   = rsp_q[0];
  assign rsp_w1   = rsp_q[1];
  assign rsp_w2   = rsp_q[2];
  assign rsp_w3   = rsp_q[3];

  logic unused_bits;
  assign unused_bits = ^{reg_wdata[31:16], reg_wdata[14:12], rx_word[LONG_LEN-1:128]};

  AST_OE_PENDING: assert property (@(posedge clk) disable iff (!rst_s)
    cmd_oe |-> cmd_word[B_NEW]); // R2
  AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_s)
    (cmd_word[B_NEW] && wr_cmd) |=> $stable(cmd_word[11:0])); // R4
  AST_TIMEOUT_ENDS: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(status[S_CMD_TO]) |-> (!cmd_word[B_NEW] && cmd_word[B_FAIL])); // R6
  AST_BUSY_RELEASE: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(status[S_BUSY_DONE]) |-> $past(dat0_in)); // R9
  AST_NO_LONG_BUSY: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == ST_BUSY) |-> !cf_q[B_LONG]); // R11
endmodule

// File: tb/test_sd_cmd_engine.sv
module test_sd_cmd_engine;
  localparam int CLK_PERIOD = 10;
  localparam int STB_DIV    = 4;
  localparam int WDOG       = 150000;

  logic        clk = 1'b0, rst_n = 1'b0, clk_en = 1'b0, reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        cmd_in = 1'b1, dat0_in = 1'b1;
  logic        cmd_out, cmd_oe;
  logic [15:0] cmd_word;
  logic [10:0] status;
  logic [31:0] rsp_w0, rsp_w1, rsp_w2, rsp_w3;

  sd_cmd_engine i_sd_cmd_engine (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .cmd_in(cmd_in),
    .dat0_in(dat0_in), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
    .cmd_word(cmd_word), .status(status), .rsp_w0(rsp_w0),
    .rsp_w1(rsp_w1), .rsp_w2(rsp_w2), .rsp_w3(rsp_w3)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, errors = 0;
  bit run = 0, done = 0;
  bit line_q[$];
  int div = 0;

  // card side: strobe generator and command line playback
  always @(posedge clk) begin
    #1;
    if (div == STB_DIV - 1) begin
      div    = 0;
      clk_en = 1'b1;
      cmd_in = (line_q.size() > 0) ? line_q.pop_front() : 1'b1;
    end else begin
      div++;
      clk_en = 1'b0;
    end
  end

  function automatic logic [6:0] ref_crc(logic [39:0] h);
    longint r;
    r = longint'(h) << 7;
    for (int i = 46; i >= 7; i--)
      if (r[i]) r = r ^ (longint'(8'h89) << (i - 7));
    return r[6:0];
  endfunction

  task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int         m_st;
  bit         m_new, m_fail;
  bit [11:0]  m_cf;
  bit [31:0]  m_arg, m_tmo_reg;
  bit [10:0]  m_sts;
  bit [31:0]  m_r[4];
  longint     m_tcnt;
  bit         m_tx_q[$];
  bit         m_rx_q[$];

  always @(posedge clk) begin
    bit        fin, was_new;
    bit [10:0] set, clr;
    bit [39:0] h;
    bit [6:0]  rc;
    if (!rst_n) begin
      m_st = 0; m_new = 0; m_fail = 0; m_cf = 0; m_arg = 0; m_tmo_reg = 0;
      m_sts = 0; m_tcnt = 0;
      for (int k = 0; k < 4; k++) m_r[k] = 0;
      m_tx_q.delete(); m_rx_q.delete();
    end else begin
      fin = 0; set = 0; was_new = m_new;
      case (m_st)
        1: if (clk_en) begin
          void'(m_tx_q.pop_front());
          if (m_tx_q.size() == 0) begin
            if (m_cf[10]) fin = 1;
            else begin m_st = 2; m_tcnt = m_tmo_reg; end
          end
        end
        2: if (clk_en) begin
          if (!cmd_in) begin m_rx_q.delete(); m_rx_q.push_back(1'b0); m_st = 3; end
          else if (m_tcnt == 0) begin set[6] = 1; m_fail = 1; fin = 1; end
          else m_tcnt--;
        end
        3: if (clk_en) begin
          m_rx_q.push_back(cmd_in);
          if (m_rx_q.size() == (m_cf[9] ? 136 : 48)) begin
            if (m_cf[9]) begin
              for (int j = 0; j < 128; j++) m_r[j / 32][j % 32] = m_rx_q[135 - j];
              fin = 1;
            end else begin
              for (int j = 8; j < 40; j++) m_r[0][j - 8] = m_rx_q[47 - j];
              for (int i = 0; i < 40; i++) h[i] = m_rx_q[47 - (i + 8)];
              for (int k = 1; k < 8; k++) rc[k - 1] = m_rx_q[47 - k];
              if (ref_crc(h) != rc) begin set[4] = 1; m_fail = 1; fin = 1; end
              else if (m_cf[11]) begin m_st = 4; m_tcnt = m_tmo_reg; end
              else fin = 1;
            end
          end
        end
        4: if (clk_en) begin
          if (dat0_in) begin set[10] = 1; fin = 1; end
          else if (m_tcnt == 0) begin set[7] = 1; m_fail = 1; fin = 1; end
          else m_tcnt--;
        end
        default: ;
      endcase
      if (fin) begin m_st = 0; m_new = 0; end
      if (reg_wr && reg_addr == 2'd0 && !was_new) begin
        m_cf = reg_wdata[11:0] & 12'hEFF;
        if (reg_wdata[15]) begin
          if (reg_wdata[9] && reg_wdata[11]) m_fail = 1;
          else begin
            m_new = 1; m_fail = 0; m_st = 1;
            h = {2'b01, reg_wdata[5:0], m_arg};
            rc = ref_crc(h);
            m_tx_q.delete();
            for (int i = 39; i >= 0; i--) m_tx_q.push_back(h[i]);
            for (int i = 6; i >= 0; i--) m_tx_q.push_back(rc[i]);
            m_tx_q.push_back(1'b1);
          end
        end
      end
      if (reg_wr && reg_addr == 2'd1) m_arg = reg_wdata;
      if (reg_wr && reg_addr == 2'd2) m_tmo_reg = reg_wdata;
      clr = (reg_wr && reg_addr == 2'd3) ? reg_wdata[10:0] : 11'd0;
      m_sts = (m_sts & ~clr) | set;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (run && !done) begin
      chk("R3", "cmd_oe", 128'(cmd_oe), 128'(m_st == 1));
      chk("R3", "cmd_out", 128'(cmd_out), 128'((m_st == 1) ? m_tx_q[0] : 1'b1));
      chk("R2", "cmd_word", 128'(cmd_word), 128'({m_new, m_fail, 2'b00, m_cf}));
      chk("R10", "status", 128'(status), 128'(m_sts));
      chk("R7", "response", {rsp_w3, rsp_w2, rsp_w1, rsp_w0},
          {m_r[3], m_r[2], m_r[1], m_r[0]});
    end
  end

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (cmd_word[15] === 1'b1 && n < 20000) begin @(negedge clk); n++; end
  endtask

  task automatic wait_sent();
    int n = 0;
    while (cmd_oe === 1'b1 && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic push_short(int dly, logic [5:0] idx, logic [31:0] pl, bit bad);
    logic [39:0] h;
    logic [6:0]  c;
    h = {2'b00, idx, pl};
    c = ref_crc(h);
    if (bad) c = c ^ 7'h01;
    repeat (dly) line_q.push_back(1'b1);
    for (int i = 39; i >= 0; i--) line_q.push_back(h[i]);
    for (int i = 6; i >= 0; i--) line_q.push_back(c[i]);
    line_q.push_back(1'b1);
  endtask

  task automatic push_long(int dly, logic [127:0] v);
    logic [7:0] hd;
    hd = 8'h3F;
    repeat (dly) line_q.push_back(1'b1);
    for (int i = 7; i >= 0; i--) line_q.push_back(hd[i]);
    for (int i = 127; i >= 0; i--) line_q.push_back(v[i]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  localparam logic [127:0] LONG_V = 128'h0123456789ABCDEF_FEDCBA9876543211;

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run = 1;
    // R1 reset state
    chk("R1", "cmd_word", 128'(cmd_word), 128'h0);
    chk("R1", "status", 128'(status), 128'h0);
    chk("R1", "response", {rsp_w3, rsp_w2, rsp_w1, rsp_w0}, 128'h0);
    chk("R1", "line", 128'({cmd_oe, cmd_out}), 128'h1);

    // R5 no-response command, frame checked by the model (R3)
    wr(2'd2, 32'd20);
    wr(2'd1, 32'h12345678);
    wr(2'd0, 32'h8000 | 32'h0400 | 32'd17);
    chk("R2", "started", 128'(cmd_word), 128'h8411);
    wait_sent();
    chk("R5", "cmd_word", 128'(cmd_word), 128'h0411);
    chk("R5", "status", 128'(status), 128'h0);

    // R7 short response, good CRC
    wr(2'd1, 32'h0000ABCD);
    wr(2'd0, 32'h8000 | 32'd8);
    wait_sent();
    push_short(3, 6'd8, 32'hCAFEF00D, 0);
    wait_idle();
    chk("R7", "rsp_w0", 128'(rsp_w0), 128'hCAFEF00D);
    chk("R7", "cmd_word", 128'(cmd_word), 128'h0008);

    // R7 short response, bad CRC
    wr(2'd0, 32'h8000 | 32'd13);
    wait_sent();
    push_short(2, 6'd13, 32'h0BADBEEF, 1);
    wait_idle();
    chk("R7", "crc status", 128'(status), 128'h010);
    chk("R7", "fail", 128'(cmd_word), 128'h400D);

    // R10 write-one-to-clear
    wr(2'd3, 32'h7FF);
    chk("R10", "cleared", 128'(status), 128'h0);

    // R12 start clears fail
    wr(2'd0, 32'h8000 | 32'h0400 | 32'd2);
    chk("R12", "fail cleared", 128'(cmd_word), 128'h8402);
    wait_idle();

    // R6 response timeout
    wr(2'd2, 32'd5);
    wr(2'd0, 32'h8000 | 32'd9);
    wait_idle();
    chk("R6", "timeout status", 128'(status), 128'h040);
    chk("R6", "fail", 128'(cmd_word), 128'h4009);
    wr(2'd3, 32'h040);

    // R4 write while pending is ignored
    wr(2'd0, 32'h8000 | 32'h0400 | 32'd5);
    repeat (20) @(negedge clk);
    wr(2'd0, 32'h8000 | 32'h0400 | 32'd33);
    chk("R4", "pending", 128'(cmd_word), 128'h8405);
    wait_idle();
    chk("R4", "after", 128'(cmd_word), 128'h0405);

    // R8 long response
    wr(2'd2, 32'd20);
    wr(2'd0, 32'h8000 | 32'h0200 | 32'd2);
    wait_sent();
    push_long(4, LONG_V);
    wait_idle();
    chk("R8", "words", {rsp_w3, rsp_w2, rsp_w1, rsp_w0}, LONG_V);
    chk("R8", "cmd_word", 128'(cmd_word), 128'h0202);

    // R9 busy released
    dat0_in = 1'b0;
    wr(2'd0, 32'h8000 | 32'h0800 | 32'd7);
    wait_sent();
    push_short(2, 6'd7, 32'h00000900, 0);
    while (line_q.size() > 0) @(negedge clk);
    repeat (40) @(negedge clk);
    chk("R9", "held busy", 128'(cmd_word[15]), 128'h1);
    dat0_in = 1'b1;
    wait_idle();
    chk("R9", "busy done", 128'(status), 128'h400);
    chk("R7", "upper kept", 128'(rsp_w3), 128'(LONG_V[127:96]));
    wr(2'd3, 32'h400);

    // R9 busy timeout
    wr(2'd2, 32'd5);
    dat0_in = 1'b0;
    wr(2'd0, 32'h8000 | 32'h0800 | 32'd6);
    wait_sent();
    push_short(1, 6'd6, 32'h00000001, 0);
    wait_idle();
    chk("R9", "busy timeout", 128'(status), 128'h080);
    chk("R9", "fail", 128'(cmd_word), 128'h4806);
    dat0_in = 1'b1;
    wr(2'd3, 32'h080);

    // R11 long + busy rejected
    wr(2'd0, 32'h8000 | 32'h0A00 | 32'd3);
    chk("R11", "rejected", 128'(cmd_word), 128'h4A03);
    repeat (40) @(negedge clk);
    chk("R11", "no drive", 128'(cmd_oe), 128'h0);

    repeat (5) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end
endmodule